// File: doc/BRIEF.md
# Segmented Flash Program/Erase Controller

This block sits between a CPU-side command channel and a behavioural byte-wide flash array. The array has two regions of different granularity. The main region is a run of large segments. The information region is a pair of small segments, called A and B. The controller accepts byte programs, word programs, single-segment erases and a bulk erase, and it applies each one to the array. It then holds a busy indication for a configurable number of clock cycles. A separate read port returns stored bytes when the controller is idle.

Flash semantics are modelled directly. An erase drives every byte of its range to 0xFF. A program can only clear bits, so the stored byte becomes the old value ANDed with the new one. The bulk erase always clears the whole main region. A per-command select decides whether it also clears both information segments. Any attempt to touch the array while an operation is in progress is discarded, and it raises a sticky access-violation flag.

The command channel uses a valid/ready handshake. The controller never applies back-pressure: `cmd_ready` is high whenever reset is not asserted. A command presented while `busy` is high is still consumed, but it is discarded and counted as a violation. A producer must therefore wait for `busy` to fall before it presents the next command. Control, status and read pins are plain signals.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset, `busy` and `acc_viol` are 0 and `cmd_ready` is 1.
- R2: Byte program (`cmd_op` = 0) stores old AND `cmd_wdata[7:0]` at `cmd_addr`.
- R3: Word program (`cmd_op` = 1) ignores address bit 0. It ANDs `cmd_wdata[7:0]` into the even byte and `cmd_wdata[15:8]` into the following odd byte.
- R4: Segment erase (`cmd_op` = 2) with an address in the main region (below MAIN_SEGS*MAIN_SEG_BYTES) sets to 0xFF every byte of the main segment that holds the address. All other bytes are left unchanged.
- R5: Segment erase with an address in the information region sets to 0xFF only the information segment that holds the address. Segment A starts right after the main region, and segment B follows A.
- R6: Bulk erase (`cmd_op` = 3) with `cmd_incl_info` = 0 sets the whole main region to 0xFF and leaves both information segments unchanged.
- R7: Bulk erase with `cmd_incl_info` = 1 sets every byte of both regions to 0xFF.
- R8: `busy` rises in the cycle after a command is accepted. It stays high for exactly `cfg_write_cycles` cycles after a program, or exactly `cfg_erase_cycles` cycles after an erase. A value of 0 counts as 1.
- R9: A command presented while `busy` is high changes no byte of the array, and `acc_viol` reads 1 from the next cycle on.
- R10: A read requested while `busy` is high leaves `rd_data` unchanged, and `acc_viol` reads 1 from the next cycle on.
- R11: `acc_viol` stays high until `viol_clr` is asserted in a cycle with no new violation. When a new violation and `viol_clr` arrive in the same cycle, the flag stays set.
- R12: A read requested while idle presents the byte at `rd_addr` on `rd_data` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command channel can accept (high out of reset) |
| cmd_op | input | 2 | 0 byte program, 1 word program, 2 segment erase, 3 bulk erase |
| cmd_addr | input | ADDR_W | Byte address of the command |
| cmd_wdata | input | 16 | Program data |
| cmd_incl_info | input | 1 | Bulk erase also clears the information segments |
| cfg_write_cycles | input | CNT_W | Busy length of a program |
| cfg_erase_cycles | input | CNT_W | Busy length of an erase |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Operation in progress |
| acc_viol | output | 1 | Sticky access-violation flag |
| viol_clr | input | 1 | Clear request for the violation flag |

## Verification
The bench builds the controller with two main segments of 16 bytes and two information segments of 8 bytes. With these sizes every byte of the 48-byte array can be read back and compared with a model after each operation. The reduced sizes keep the real segment boundaries: the main-to-information seam, the A/B seam, and a word program whose address has bit 0 set. This exposes any erase that spills across a boundary or misses part of its range. The busy lengths of 3 and 7 cycles, plus a zero setting, keep the program and erase timings and the minimum-length case separately measurable.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  typedef enum logic [1:0] {
    OP_WR_BYTE = 2'd0,
    OP_WR_WORD = 2'd1,
    OP_ER_SEG  = 2'd2,
    OP_ER_BULK = 2'd3
  } flash_op_e;
endpackage

// File: rtl/flash_range_dec.sv
module flash_range_dec
  import flash_ctl_pkg::*;
#(
  parameter int MAIN_SEGS      = 4,
  parameter int MAIN_SEG_BYTES = 512,
  parameter int INFO_SEG_BYTES = 128,
  parameter int ADDR_W         = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  flash_op_e         op,
  input  logic              incl_info,
  output logic              in_range,
  output logic [ADDR_W:0]   er_lo,
  output logic [ADDR_W:0]   er_hi,
  output logic [ADDR_W-1:0] wr_a0,
  output logic [ADDR_W-1:0] wr_a1,
  output logic              wr_two
);
  localparam int AW1        = ADDR_W + 1;
  localparam int MAIN_BYTES = MAIN_SEGS * MAIN_SEG_BYTES;
  localparam int TOTAL      = MAIN_BYTES + 2 * INFO_SEG_BYTES;
  localparam logic [ADDR_W:0] MAIN_B = AW1'(MAIN_BYTES);
  localparam logic [ADDR_W:0] TOT_B  = AW1'(TOTAL);
  localparam logic [ADDR_W:0] MSEG   = AW1'(MAIN_SEG_BYTES);
  localparam logic [ADDR_W:0] ISEG   = AW1'(INFO_SEG_BYTES);

  logic [ADDR_W:0] a_ext;
  logic [ADDR_W:0] info_off;

  always_comb begin
    a_ext    = {1'b0, addr};
    info_off = a_ext - MAIN_B;
    in_range = (a_ext < TOT_B);
    if (op == OP_ER_BULK) begin
      er_lo = '0;
      er_hi = incl_info ? TOT_B : MAIN_B;
    end else if (a_ext < MAIN_B) begin
      er_lo = a_ext & ~(MSEG - AW1'(1));
      er_hi = er_lo + MSEG;
    end else begin
      er_lo = MAIN_B + (info_off & ~(ISEG - AW1'(1)));
      er_hi = er_lo + ISEG;
    end
    wr_two = (op == OP_WR_WORD);
    wr_a0  = wr_two ? {addr[ADDR_W-1:1], 1'b0} : addr;
    wr_a1  = {addr[ADDR_W-1:1], 1'b1};
  end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] cycles,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= (cycles == '0) ? CNT_W'(1) : cycles;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) busy <= 1'b0;
    end
  end

  // R9
  start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
endmodule

// File: rtl/flash_store.sv
module flash_store #(
  parameter int TOTAL  = 2304,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_two,
  input  logic [ADDR_W-1:0] wr_a0,
  input  logic [ADDR_W-1:0] wr_a1,
  input  logic [15:0]       wr_d,
  input  logic              er_en,
  input  logic [ADDR_W:0]   er_lo,
  input  logic [ADDR_W:0]   er_hi,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int AW1 = ADDR_W + 1;
  localparam logic [ADDR_W:0] TOT_B = AW1'(TOTAL);

  logic [7:0] cells [TOTAL];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if ({1'b0, wr_a0} < TOT_B) cells[wr_a0] <= cells[wr_a0] & wr_d[7:0];
      if (wr_two && ({1'b0, wr_a1} < TOT_B)) cells[wr_a1] <= cells[wr_a1] & wr_d[15:8];
    end
    if (er_en) begin
      for (int i = 0; i < TOTAL; i++) begin
        if (AW1'(i) >= er_lo && AW1'(i) < er_hi) cells[i] <= 8'hFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else if (rd_go) rd_data <= ({1'b0, rd_addr} < TOT_B) ? cells[rd_addr] : 8'hFF;
  end

  // R4
  erase_range_chk: assert property (@(posedge clk) disable iff (rst)
    er_en |-> (er_hi > er_lo) && (er_hi <= TOT_B));
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_ctl_pkg::*;
#(
  parameter int MAIN_SEGS      = 4,
  parameter int MAIN_SEG_BYTES = 512,
  parameter int INFO_SEG_BYTES = 128,
  parameter int CNT_W          = 16,
  parameter int ADDR_W         = $clog2(MAIN_SEGS * MAIN_SEG_BYTES + 2 * INFO_SEG_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [15:0]       cmd_wdata,
  input  logic              cmd_incl_info,
  input  logic [CNT_W-1:0]  cfg_write_cycles,
  input  logic [CNT_W-1:0]  cfg_erase_cycles,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              acc_viol,
  input  logic              viol_clr
);
  localparam int TOTAL = MAIN_SEGS * MAIN_SEG_BYTES + 2 * INFO_SEG_BYTES;

  flash_op_e         op;
  logic              accept, is_erase, in_range;
  logic              wr_en, er_en, rd_go, wr_two;
  logic [ADDR_W:0]   er_lo, er_hi;
  logic [ADDR_W-1:0] wr_a0, wr_a1;

  assign op        = flash_op_e'(cmd_op);
  assign cmd_ready = ~rst;
  assign accept    = cmd_valid & cmd_ready & ~busy;
  assign is_erase  = (op == OP_ER_SEG) || (op == OP_ER_BULK);
  assign wr_en     = accept & ~is_erase & in_range;
  assign er_en     = accept & is_erase & (in_range | (op == OP_ER_BULK));
  assign rd_go     = rd_en & ~busy;

  flash_range_dec #(
    .MAIN_SEGS(MAIN_SEGS), .MAIN_SEG_BYTES(MAIN_SEG_BYTES),
    .INFO_SEG_BYTES(INFO_SEG_BYTES), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(cmd_addr), .op(op), .incl_info(cmd_incl_info), .in_range(in_range),
    .er_lo(er_lo), .er_hi(er_hi), .wr_a0(wr_a0), .wr_a1(wr_a1), .wr_two(wr_two)
  );

  flash_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .start(accept),
    .cycles(is_erase ? cfg_erase_cycles : cfg_write_cycles), .busy(busy)
  );

  flash_store #(.TOTAL(TOTAL), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_two(wr_two), .wr_a0(wr_a0),
    .wr_a1(wr_a1), .wr_d(cmd_wdata), .er_en(er_en), .er_lo(er_lo),
    .er_hi(er_hi), .rd_go(rd_go), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) acc_viol <= 1'b0;
    else if (busy && (cmd_valid || rd_en)) acc_viol <= 1'b1;
    else if (viol_clr) acc_viol <= 1'b0;
  end

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !busy |=> busy);
  // R9
  cmd_viol_chk: assert property (@(posedge clk) disable iff (rst)
    busy && cmd_valid |=> acc_viol);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && rd_en |=> $stable(rd_data) && acc_viol);
  // R11
  viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    acc_viol && !viol_clr |=> acc_viol);
endmodule

// File: tb/flash_seq_ctrl_tb.sv
module flash_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MS = 2, MSB = 16, ISB = 8, CW = 8;
  localparam int MAINB = MS * MSB;
  localparam int TOT = MAINB + 2 * ISB;
  localparam int AW = $clog2(TOT);
  localparam int WCYC = 3, ECYC = 7;

  typedef struct packed {
    logic [1:0]  op;
    logic [5:0]  addr;
    logic [15:0] data;
    logic        incl;
    logic [5:0]  caddr;
    logic [7:0]  exp;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'd3, 6'd0,  16'h0000, 1'b1, 6'd45, 8'hFF},
    '{2'd0, 6'd3,  16'h00A5, 1'b0, 6'd3,  8'hA5},
    '{2'd0, 6'd3,  16'h003C, 1'b0, 6'd3,  8'h24},
    '{2'd1, 6'd7,  16'h1234, 1'b0, 6'd6,  8'h34},
    '{2'd1, 6'd33, 16'hBEEF, 1'b0, 6'd33, 8'hBE},
    '{2'd1, 6'd42, 16'h0F0F, 1'b0, 6'd42, 8'h0F},
    '{2'd0, 6'd20, 16'h0000, 1'b0, 6'd20, 8'h00},
    '{2'd2, 6'd9,  16'h0000, 1'b0, 6'd3,  8'hFF},
    '{2'd2, 6'd44, 16'h0000, 1'b0, 6'd42, 8'hFF},
    '{2'd0, 6'd25, 16'h0081, 1'b0, 6'd25, 8'h81},
    '{2'd3, 6'd0,  16'h0000, 1'b0, 6'd25, 8'hFF},
    '{2'd3, 6'd0,  16'h0000, 1'b1, 6'd33, 8'hFF}
  };

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_ready, cmd_incl_info = 0;
  logic [1:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0, rd_addr = 0;
  logic [15:0] cmd_wdata = 0;
  logic [CW-1:0] cfg_write_cycles = CW'(WCYC), cfg_erase_cycles = CW'(ECYC);
  logic rd_en = 0, viol_clr = 0;
  logic [7:0] rd_data;
  logic busy, acc_viol;

  int checks = 0, errors = 0;
  logic [7:0] model [TOT];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_seq_ctrl #(.MAIN_SEGS(MS), .MAIN_SEG_BYTES(MSB), .INFO_SEG_BYTES(ISB), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_incl_info(cmd_incl_info),
    .cfg_write_cycles(cfg_write_cycles), .cfg_erase_cycles(cfg_erase_cycles),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .acc_viol(acc_viol), .viol_clr(viol_clr)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input int addr, input logic [15:0] d, input logic incl);
    cmd_valid = 1; cmd_op = op; cmd_addr = AW'(addr); cmd_wdata = d; cmd_incl_info = incl;
    tick();
    cmd_valid = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic rd(input int addr, output logic [7:0] d);
    rd_en = 1; rd_addr = AW'(addr);
    tick();
    rd_en = 0; d = rd_data;
  endtask

  task automatic model_apply(input logic [1:0] op, input int addr, input logic [15:0] d, input logic incl);
    int lo, hi, e;
    case (op)
      2'd0: model[addr] = model[addr] & d[7:0];
      2'd1: begin
        e = addr & ~1;
        model[e] = model[e] & d[7:0];
        model[e+1] = model[e+1] & d[15:8];
      end
      2'd2: begin
        if (addr < MAINB) begin lo = (addr / MSB) * MSB; hi = lo + MSB; end
        else begin lo = MAINB + ((addr - MAINB) / ISB) * ISB; hi = lo + ISB; end
        for (int i = lo; i < hi; i++) model[i] = 8'hFF;
      end
      default: begin
        hi = incl ? TOT : MAINB;
        for (int i = 0; i < hi; i++) model[i] = 8'hFF;
      end
    endcase
  endtask

  task automatic compare_all(input string tag);
    logic [7:0] d;
    for (int i = 0; i < TOT; i++) begin
      rd(i, d);
      check(tag, d, model[i]);
    end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    logic [7:0] d;
    for (int i = 0; i < TOT; i++) model[i] = 8'hFF;
    repeat (3) tick();
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 acc_viol", acc_viol, 0);
    check("R1 cmd_ready", cmd_ready, 1);

    for (int v = 0; v < 12; v++) begin
      issue(VECS[v].op, VECS[v].addr, VECS[v].data, VECS[v].incl);
      wait_idle(n);
      check("R8 busy length", n, (VECS[v].op >= 2) ? ECYC : WCYC);
      model_apply(VECS[v].op, VECS[v].addr, VECS[v].data, VECS[v].incl);
      rd(VECS[v].caddr, d);
      case (VECS[v].op)
        2'd0: check("R2 byte program", d, VECS[v].exp);
        2'd1: check("R3 word program", d, VECS[v].exp);
        2'd2: check("R4 R5 segment erase", d, VECS[v].exp);
        default: check("R6 R7 bulk erase", d, VECS[v].exp);
      endcase
      compare_all("R4 R5 R6 R7 R12 array contents");
    end

    // R8 zero setting counts as one cycle
    cfg_write_cycles = '0;
    issue(2'd0, 1, 16'h00F0, 1'b0);
    wait_idle(n);
    check("R8 zero busy length", n, 1);
    model_apply(2'd0, 1, 16'h00F0, 1'b0);
    cfg_write_cycles = CW'(WCYC);

    // R9 command during busy is dropped and flagged
    issue(2'd2, 0, 16'h0000, 1'b0);
    model_apply(2'd2, 0, 16'h0000, 1'b0);
    cmd_valid = 1; cmd_op = 2'd0; cmd_addr = AW'(5); cmd_wdata = 16'h0000;
    tick();
    cmd_valid = 0;
    check("R9 acc_viol set", acc_viol, 1);
    wait_idle(n);
    rd(5, d);
    check("R9 dropped program", d, 8'hFF);

    // R11 clear with no new violation
    viol_clr = 1; tick(); viol_clr = 0;
    check("R11 cleared", acc_viol, 0);

    // R12 and R10: known read value, then read attempt during busy
    issue(2'd0, 2, 16'h005A, 1'b0);
    wait_idle(n);
    model_apply(2'd0, 2, 16'h005A, 1'b0);
    rd(2, d);
    check("R12 read", d, 8'h5A);
    issue(2'd3, 0, 16'h0000, 1'b1);
    model_apply(2'd3, 0, 16'h0000, 1'b1);
    rd_en = 1; rd_addr = AW'(2); viol_clr = 1;
    tick();
    rd_en = 0; viol_clr = 0;
    check("R10 rd_data held", rd_data, 8'h5A);
    check("R11 set wins over clear", acc_viol, 1);
    wait_idle(n);
    check("R11 sticky after idle", acc_viol, 1);
    viol_clr = 1; tick(); viol_clr = 0;
    check("R11 cleared again", acc_viol, 0);
    compare_all("R7 final contents");

    finish_run();
  end
endmodule